// File: doc/BRIEF.md
# Page-One Stack and Status Unit

This block keeps the register state an 8-bit processor core needs around its stack. It holds the accumulator, six stored status flags and an 8-bit stack pointer. It runs the implied stack operations against a synchronous single-port memory: push or pull of the accumulator, and push or pull of the status byte. Every stack access lands in memory page one, so the pointer only supplies the low address byte. The pointer wraps inside the page and never leaves it.

A subroutine-call sequencer or an interrupt-entry sequencer shares the same stack through two raw byte operations. Push-byte stores a byte that the sequencer supplies. Pull-byte returns a byte on a strobed output and leaves the accumulator and the flags alone. Interrupt entry has its own status-push code, which stores the break bit as 0. The break bit has no storage in the block. It exists only in the copy of the status byte that goes to memory.

The core's datapath loads the accumulator and the flags directly through two write ports. Instruction decode, the ALU and the program counter are not part of this block.

Top module: `stk_status_unit`

## Requirements
- R1: After reset, busy is low, the accumulator reads 0x00, the status output reads 0x24 (only the interrupt-disable flag set), the stack pointer reads 0xFF, and mem_we, mem_re and pull_valid are low.
- R2: Every memory access drives 0x01 on mem_addr[15:8]. mem_we and mem_re are never high together, and neither is high while busy is low.
- R3: A push writes to address {0x01, S} and then decrements S by one modulo 256, so S goes from 0x00 to 0xFF.
- R4: A pull first increments S by one modulo 256, so S goes from 0xFF to 0x00, and then reads from address {0x01, S} with the new S.
- R5: Operation code 0 (push accumulator) writes the accumulator value that was current when the request was accepted.
- R6: The status byte layout is, from bit 7 down to bit 0: N, V, 1, B, D, I, Z, C. Code 1 (push status by instruction) writes it with B=1. Code 6 (push status on interrupt entry) writes it with B=0.
- R7: Code 3 (pull status) loads N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0 of the byte read, and ignores bits 5 and 4. The live status output always shows bit 5 as 1 and bit 4 as 0.
- R8: Code 2 (pull accumulator) loads the byte into the accumulator, sets N to bit 7 of that byte and Z to whether it is zero, and leaves V, D, I and C unchanged.
- R9: Code 4 (push byte) writes the push_data value sampled when the request is accepted. Code 5 (pull byte) presents the byte read on pull_data, with pull_valid high for exactly one cycle. Neither changes the accumulator or the flags.
- R10: A request is accepted on a clock edge where req_valid is high and busy is low. A push holds busy high for one cycle, and mem_we is high in that cycle. A pull holds busy high for two cycles, with mem_re high in the first. Pulled results are visible in the cycle after the second.
- R11: A request made while busy is high is ignored. Code 7 is ignored at any time: no busy, no memory access, no change of state.
- R12: acc_wr_en loads acc_wr_data into the accumulator on the next edge. flag_wr_en loads the flags from flag_wr_data using the bit positions of R7. A capture from a pull that targets the same register in that same edge takes precedence over the direct load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Stack operation request |
| req_op | input | 3 | Operation code (0 to 6 as in R5 to R9; 7 means none) |
| push_data | input | 8 | Byte for the push-byte operation |
| pull_data | output | 8 | Byte returned by the pull-byte operation |
| pull_valid | output | 1 | One-cycle strobe qualifying pull_data |
| acc_wr_en | input | 1 | Direct accumulator load enable |
| acc_wr_data | input | 8 | Direct accumulator load value |
| flag_wr_en | input | 1 | Direct flag load enable |
| flag_wr_data | input | 8 | Direct flag load value in status layout |
| acc | output | 8 | Accumulator |
| status | output | 8 | Live status byte, bit 5 = 1, bit 4 = 0 |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |

## Verification
The directed part starts from reset with a pull and then a push. This pushes the pointer across both wrap points and tells modulo wrapping apart from saturation or a page change. A second directed group uses status pushes with every flag set, plus pulls of 0x00, 0x80, 0x30 and 0xCF. These separate the two break-bit sources, confirm that pulled bits 5 and 4 are dropped, and show that the N and Z derivation on an accumulator pull is independent of the other flags. A seeded random mix of all seven operations, direct loads and requests issued while busy is then compared against a bench model of the page and the registers. This exposes ordering mistakes such as decrementing before writing or reading before incrementing, and any acceptance of a request during an operation.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [2:0] {
      OP_PUSH_A     = 3'd0,
      OP_PUSH_P     = 3'd1,
      OP_PULL_A     = 3'd2,
      OP_PULL_P     = 3'd3,
      OP_PUSH_BYTE  = 3'd4,
      OP_PULL_BYTE  = 3'd5,
      OP_PUSH_P_IRQ = 3'd6,
      OP_NONE       = 3'd7
   } stk_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_CAP  = 2'd2
   } stk_state_e;

   // stored flags, packed most significant first
   typedef struct packed {
      logic n;
      logic v;
      logic d;
      logic i;
      logic z;
      logic c;
   } stk_flags_t;

   // status byte positions (the bit order is what memory sees)
   localparam int unsigned SB_N   = 7;
   localparam int unsigned SB_V   = 6;
   localparam int unsigned SB_ONE = 5;
   localparam int unsigned SB_BRK = 4;
   localparam int unsigned SB_D   = 3;
   localparam int unsigned SB_I   = 2;
   localparam int unsigned SB_Z   = 1;
   localparam int unsigned SB_C   = 0;

   function automatic logic [7:0] stk_pack(stk_flags_t f, logic brk);
      logic [7:0] b;
      b         = '0;
      b[SB_N]   = f.n;
      b[SB_V]   = f.v;
      b[SB_ONE] = 1'b1;
      b[SB_BRK] = brk;
      b[SB_D]   = f.d;
      b[SB_I]   = f.i;
      b[SB_Z]   = f.z;
      b[SB_C]   = f.c;
      return b;
   endfunction

   function automatic stk_flags_t stk_unpack(logic [7:0] b);
      stk_flags_t f;
      f.n = b[SB_N];
      f.v = b[SB_V];
      f.d = b[SB_D];
      f.i = b[SB_I];
      f.z = b[SB_Z];
      f.c = b[SB_C];
      return f;
   endfunction

   function automatic logic stk_is_push(stk_op_e op);
      return (op == OP_PUSH_A) || (op == OP_PUSH_P) ||
             (op == OP_PUSH_BYTE) || (op == OP_PUSH_P_IRQ);
   endfunction

   function automatic logic stk_is_pull(stk_op_e op);
      return (op == OP_PULL_A) || (op == OP_PULL_P) || (op == OP_PULL_BYTE);
   endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [2:0] req_op,
   output logic       accept,
   output stk_op_e    cur_op,
   output logic       busy,
   output logic       sp_inc,
   output logic       sp_dec,
   output logic       mem_we,
   output logic       mem_re,
   output logic       capture
);

   stk_state_e state_q;
   stk_state_e state_d;
   stk_op_e    op_in;

   assign op_in  = stk_op_e'(req_op);
   assign busy   = (state_q != ST_IDLE);
   assign accept = req_valid && !busy && (op_in != OP_NONE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept) state_d = ST_MEM;
         ST_MEM:  state_d = stk_is_pull(cur_op) ? ST_CAP : ST_IDLE;
         ST_CAP:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_op  <= OP_NONE;
      end else begin
         state_q <= state_d;
         if (accept) cur_op <= op_in;
      end
   end

   // pull pre-increments on the accept edge; push post-decrements on its memory edge
   assign sp_inc  = accept && stk_is_pull(op_in);
   assign mem_we  = (state_q == ST_MEM) && stk_is_push(cur_op);
   assign mem_re  = (state_q == ST_MEM) && stk_is_pull(cur_op);
   assign sp_dec  = mem_we;
   assign capture = (state_q == ST_CAP);

   assert_accept_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (mem_we || mem_re));
   assert_push_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !busy);
   assert_pull_two_cycles_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (busy && !mem_re && !mem_we));
   assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |-> !accept);
   assert_no_dual_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
   parameter int unsigned DW         = 8,
   parameter int unsigned AW         = 16,
   parameter int unsigned STACK_PAGE = 1,
   parameter int unsigned SP_RESET   = 255
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [DW-1:0] sp,
   output logic [AW-1:0] addr
);

   localparam int unsigned PW = AW - DW;
   localparam logic [PW-1:0] PAGE   = PW'(STACK_PAGE);
   localparam logic [DW-1:0] STEP   = DW'(1);
   localparam logic [DW-1:0] SP_RST = DW'(SP_RESET);

   generate
      if (STACK_PAGE >= (64'd1 << PW)) begin : g_page_too_wide
         $error("stk_ptr: STACK_PAGE does not fit in the high address bits");
      end
      if (SP_RESET >= (64'd1 << DW)) begin : g_reset_too_wide
         $error("stk_ptr: SP_RESET does not fit in the pointer");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   sp <= SP_RST;
      else if (inc) sp <= sp + STEP;
      else if (dec) sp <= sp - STEP;
   end

   assign addr = {PAGE, sp};

   assert_no_inc_and_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec));
   assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !dec) |=> $stable(sp));

endmodule

// File: rtl/stk_regs.sv
module stk_regs
   import stk_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter logic [7:0]  ACC_RESET   = 8'h00,
   parameter logic [5:0]  FLAGS_RESET = 6'b000100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_wr_en,
   input  logic [DW-1:0] acc_wr_data,
   input  logic          flag_wr_en,
   input  logic [7:0]    flag_wr_data,
   input  logic          cap_en,
   input  stk_op_e       cap_op,
   input  logic [DW-1:0] cap_data,
   output logic [DW-1:0] acc,
   output stk_flags_t    flags
);

   logic cap_a;
   logic cap_p;

   assign cap_a = cap_en && (cap_op == OP_PULL_A);
   assign cap_p = cap_en && (cap_op == OP_PULL_P);

   always_ff @(posedge clk) begin
      if (!rst_n)          acc <= DW'(ACC_RESET);
      else if (cap_a)      acc <= cap_data;
      else if (acc_wr_en)  acc <= acc_wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= stk_flags_t'(FLAGS_RESET);
      end else if (cap_p) begin
         flags <= stk_unpack(cap_data);
      end else if (cap_a) begin
         flags.n <= cap_data[DW-1];
         flags.z <= (cap_data == '0);
      end else if (flag_wr_en) begin
         flags <= stk_unpack(flag_wr_data);
      end
   end

   assert_pull_a_nz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_a |=> (acc == $past(cap_data)) && (flags.n == acc[DW-1]) && (flags.z == (acc == '0)));
   assert_pull_a_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_a |=> (flags.v == $past(flags.v)) && (flags.d == $past(flags.d)) &&
                (flags.i == $past(flags.i)) && (flags.c == $past(flags.c)));
   assert_pull_p_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_p |=> (flags.n == $past(cap_data[SB_N])) && (flags.c == $past(cap_data[SB_C])) &&
                $stable(acc));

endmodule

// File: rtl/stk_status_unit.sv
module stk_status_unit
   import stk_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 16,
   parameter int unsigned STACK_PAGE  = 1,
   parameter int unsigned SP_RESET    = 255,
   parameter logic [7:0]  ACC_RESET   = 8'h00,
   parameter logic [5:0]  FLAGS_RESET = 6'b000100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_op,
   input  logic [DW-1:0] push_data,
   output logic [DW-1:0] pull_data,
   output logic          pull_valid,
   input  logic          acc_wr_en,
   input  logic [DW-1:0] acc_wr_data,
   input  logic          flag_wr_en,
   input  logic [7:0]    flag_wr_data,
   output logic [DW-1:0] acc,
   output logic [7:0]    status,
   output logic [DW-1:0] sp,
   output logic          busy,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic          mem_re,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);

   localparam int unsigned PW = AW - DW;
   localparam logic [DW-1:0] STEP = DW'(1);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("stk_status_unit: the status byte layout needs DW == 8");
      end
      if (AW <= DW) begin : g_bad_aw
         $error("stk_status_unit: AW must exceed DW to hold a page number");
      end
   endgenerate

   logic       accept;
   stk_op_e    cur_op;
   logic       sp_inc;
   logic       sp_dec;
   logic       capture;
   stk_flags_t flags;
   logic [DW-1:0] wbyte_d;
   logic [DW-1:0] wbyte_q;

   stk_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .accept    (accept),
      .cur_op    (cur_op),
      .busy      (busy),
      .sp_inc    (sp_inc),
      .sp_dec    (sp_dec),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .capture   (capture)
   );

   stk_ptr #(
      .DW         (DW),
      .AW         (AW),
      .STACK_PAGE (STACK_PAGE),
      .SP_RESET   (SP_RESET)
   ) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (sp_inc),
      .dec   (sp_dec),
      .sp    (sp),
      .addr  (mem_addr)
   );

   stk_regs #(
      .DW          (DW),
      .ACC_RESET   (ACC_RESET),
      .FLAGS_RESET (FLAGS_RESET)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_wr_en    (acc_wr_en),
      .acc_wr_data  (acc_wr_data),
      .flag_wr_en   (flag_wr_en),
      .flag_wr_data (flag_wr_data),
      .cap_en       (capture),
      .cap_op       (cur_op),
      .cap_data     (mem_rdata),
      .acc          (acc),
      .flags        (flags)
   );

   // the byte to be pushed is frozen when the request is taken
   always_comb begin
      unique case (stk_op_e'(req_op))
         OP_PUSH_A:     wbyte_d = acc;
         OP_PUSH_P:     wbyte_d = stk_pack(flags, 1'b1);
         OP_PUSH_P_IRQ: wbyte_d = stk_pack(flags, 1'b0);
         OP_PUSH_BYTE:  wbyte_d = push_data;
         default:       wbyte_d = wbyte_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      wbyte_q <= '0;
      else if (accept) wbyte_q <= wbyte_d;
   end

   assign mem_wdata = wbyte_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pull_valid <= 1'b0;
         pull_data  <= '0;
      end else begin
         pull_valid <= capture && (cur_op == OP_PULL_BYTE);
         if (capture && (cur_op == OP_PULL_BYTE)) pull_data <= mem_rdata;
      end
   end

   assign status = stk_pack(flags, 1'b0);

   assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (mem_addr[AW-1:DW] == PW'(STACK_PAGE)));
   assert_access_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> busy);
   assert_push_then_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp == $past(mem_addr[DW-1:0]) - STEP));
   assert_pull_after_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> (mem_addr[DW-1:0] == $past(sp) + STEP));
   assert_push_p_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && cur_op == OP_PUSH_P) |-> (mem_wdata[SB_BRK] && mem_wdata[SB_ONE]));
   assert_irq_p_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && cur_op == OP_PUSH_P_IRQ) |-> (!mem_wdata[SB_BRK] && mem_wdata[SB_ONE]));
   assert_pull_strobe_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pull_valid |=> !pull_valid);

endmodule

// File: tb/sim_stk_status_unit.sv
module sim_stk_status_unit;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid;
   logic [2:0] req_op;
   logic [7:0] push_data;
   logic [7:0] pull_data;
   logic       pull_valid;
   logic       acc_wr_en;
   logic [7:0] acc_wr_data;
   logic       flag_wr_en;
   logic [7:0] flag_wr_data;
   logic [7:0] acc;
   logic [7:0] status;
   logic [7:0] sp;
   logic       busy;
   logic [15:0] mem_addr;
   logic       mem_we;
   logic       mem_re;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata = 8'h00;

   logic [7:0] ram [256] = '{default: 8'h00};

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // bench model
   logic [7:0] m_acc;
   logic [5:0] m_flags;   // n v d i z c
   logic [7:0] m_sp;
   logic [7:0] m_mem [256] = '{default: 8'h00};

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
   end

   stk_status_unit u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_op       (req_op),
      .push_data    (push_data),
      .pull_data    (pull_data),
      .pull_valid   (pull_valid),
      .acc_wr_en    (acc_wr_en),
      .acc_wr_data  (acc_wr_data),
      .flag_wr_en   (flag_wr_en),
      .flag_wr_data (flag_wr_data),
      .acc          (acc),
      .status       (status),
      .sp           (sp),
      .busy         (busy),
      .mem_addr     (mem_addr),
      .mem_we       (mem_we),
      .mem_re       (mem_re),
      .mem_wdata    (mem_wdata),
      .mem_rdata    (mem_rdata)
   );

   function automatic logic [7:0] pack_sb(input logic [5:0] f, input logic brk);
      return {f[5], f[4], 1'b1, brk, f[3], f[2], f[1], f[0]};
   endfunction

   function automatic logic [5:0] unpack_sb(input logic [7:0] b);
      return {b[7], b[6], b[3], b[2], b[1], b[0]};
   endfunction

   function automatic bit op_is_push(input logic [2:0] op);
      return (op == 3'd0) || (op == 3'd1) || (op == 3'd4) || (op == 3'd6);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      check(req, "acc", acc, m_acc);
      check(req, "status", status, pack_sb(m_flags, 1'b0));
      check(req, "sp", sp, m_sp);
   endtask

   task automatic load_acc(input logic [7:0] v);
      @(negedge clk);
      acc_wr_en = 1'b1; acc_wr_data = v;
      @(negedge clk);
      acc_wr_en = 1'b0;
      m_acc = v;
      check("R12", "acc direct load", acc, m_acc);
   endtask

   task automatic load_flags(input logic [7:0] v);
      @(negedge clk);
      flag_wr_en = 1'b1; flag_wr_data = v;
      @(negedge clk);
      flag_wr_en = 1'b0;
      m_flags = unpack_sb(v);
      check("R12", "flag direct load", status, pack_sb(m_flags, 1'b0));
   endtask

   task automatic run_op(input logic [2:0] op, input logic [7:0] pdata, input bit poke);
      logic [7:0] exp_b;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; push_data = pdata;
      @(negedge clk);
      req_valid = 1'b0;
      if (op == 3'd7) begin
         check("R11", "busy after code 7", busy, 1'b0);
         check("R11", "mem access after code 7", {mem_we, mem_re}, 2'b00);
         check_regs("R11");
      end else if (op_is_push(op)) begin
         case (op)
            3'd0:    exp_b = m_acc;
            3'd1:    exp_b = pack_sb(m_flags, 1'b1);
            3'd6:    exp_b = pack_sb(m_flags, 1'b0);
            default: exp_b = pdata;
         endcase
         check("R10", "push busy", busy, 1'b1);
         check("R2", "push strobes", {mem_we, mem_re}, 2'b10);
         check("R3", "push address", mem_addr, {8'h01, m_sp});
         check(op == 3'd0 ? "R5" : ((op == 3'd4) ? "R9" : "R6"), "push data", mem_wdata, exp_b);
         if (poke) begin
            req_valid = 1'b1; req_op = 3'd0;
         end
         @(negedge clk);
         req_valid = 1'b0;
         m_mem[m_sp] = exp_b;
         m_sp = m_sp - 8'd1;
         check("R10", "push done", busy, 1'b0);
         check("R11", "no access after push", {mem_we, mem_re}, 2'b00);
         check_regs("R3");
      end else begin
         m_sp = m_sp + 8'd1;
         check("R10", "pull busy first", busy, 1'b1);
         check("R2", "pull strobes", {mem_we, mem_re}, 2'b01);
         check("R4", "pull address", mem_addr, {8'h01, m_sp});
         if (poke) begin
            req_valid = 1'b1; req_op = 3'd0;
         end
         @(negedge clk);
         req_valid = 1'b0;
         check("R10", "pull busy second", busy, 1'b1);
         check("R11", "no access in capture", {mem_we, mem_re}, 2'b00);
         @(negedge clk);
         check("R10", "pull done", busy, 1'b0);
         exp_b = m_mem[m_sp];
         if (op == 3'd2) begin
            m_acc = exp_b;
            m_flags[5] = exp_b[7];
            m_flags[1] = (exp_b == 8'h00);
            check_regs("R8");
            check("R8", "no strobe", pull_valid, 1'b0);
         end else if (op == 3'd3) begin
            m_flags = unpack_sb(exp_b);
            check_regs("R7");
            check("R7", "no strobe", pull_valid, 1'b0);
         end else begin
            check("R9", "pull_valid", pull_valid, 1'b1);
            check("R9", "pull_data", pull_data, exp_b);
            check_regs("R9");
            @(negedge clk);
            check("R9", "pull_valid pulse ends", pull_valid, 1'b0);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd7; push_data = 8'h00;
      acc_wr_en = 1'b0; acc_wr_data = 8'h00; flag_wr_en = 1'b0; flag_wr_data = 8'h00;
      m_acc = 8'h00; m_flags = 6'b000100; m_sp = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy", busy, 1'b0);
      check("R1", "acc", acc, 8'h00);
      check("R1", "status", status, 8'h24);
      check("R1", "sp", sp, 8'hFF);
      check("R1", "strobes", {mem_we, mem_re, pull_valid}, 3'b000);

      // pointer wraps in both directions (R4 then R3)
      run_op(3'd5, 8'h00, 1'b0);
      check("R4", "wrap to 00", sp, 8'h00);
      run_op(3'd0, 8'h00, 1'b0);
      check("R3", "wrap to FF", sp, 8'hFF);

      load_acc(8'h5A);
      load_flags(8'hFF);
      check("R7", "live status with all flags", status, 8'hEF);
      run_op(3'd1, 8'h00, 1'b0);   // R6 expects 0xFF
      run_op(3'd6, 8'h00, 1'b0);   // R6 expects 0xEF
      run_op(3'd0, 8'h00, 1'b0);   // R5
      run_op(3'd2, 8'h00, 1'b0);   // R8 0x5A
      run_op(3'd4, 8'h00, 1'b0);
      run_op(3'd2, 8'h00, 1'b0);   // R8 zero
      run_op(3'd4, 8'h80, 1'b0);
      run_op(3'd2, 8'h00, 1'b0);   // R8 negative
      run_op(3'd4, 8'h30, 1'b0);
      run_op(3'd3, 8'h00, 1'b0);   // R7 bits 5,4 dropped
      check("R7", "status after 0x30 pull", status, 8'h20);
      run_op(3'd4, 8'hCF, 1'b0);
      run_op(3'd3, 8'h00, 1'b0);
      check("R7", "status after 0xCF pull", status, 8'hEF);
      run_op(3'd7, 8'h00, 1'b0);   // R11
      run_op(3'd4, 8'hA5, 1'b1);   // R11 poke during push
      run_op(3'd5, 8'h00, 1'b1);   // R11 poke during pull, R9

      void'($urandom(32'd4242));
      for (int k = 0; k < 600; k++) begin
         int unsigned pick;
         pick = $urandom_range(0, 9);
         if (pick == 8)      load_acc(8'($urandom));
         else if (pick == 9) load_flags(8'($urandom));
         else run_op(3'($urandom_range(0, 7)), 8'($urandom), 1'($urandom));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule